// File: doc/BRIEF.md
# Shared Line-Buffer Array with Miss Arbiter

This block sits between a group of near-memory coprocessors and one main-memory port. It holds one line buffer per requester plus one extra buffer, driven by its own requester port, that keeps convolution weights close to every coprocessor. Each line is a run of consecutive words starting at a base address that may be any word address. It does not have to be a multiple of the line length. This lets a sliding convolution window keep reusing a line that starts wherever the window first touched memory.

Every request is checked at once against all valid lines. When the address falls inside a line, that line serves the read or takes the write in the same cycle. When no line covers the address, the requester waits. A round-robin arbiter picks one waiting requester at a time and reloads that requester's own line from main memory, starting at the missed address. If the line had been written since it was loaded, its old contents are first copied back to memory. The grant then comes as an ordinary hit.

Top module: `nmc_share_buf`

## Requirements
- R1: After reset every line is invalid, no grant is given and the memory port is idle (`mem_req` low), so the first access to any address misses.
- R2: A request hits when its address A satisfies base <= A <= base+WORDS-1 for some valid line. In that case `gnt` is high in the same cycle and, for a read, `rdata` carries the word at offset A-base of that line.
- R3: On a miss, `gnt` stays low while the requester's own line is reloaded. Reload takes WORDS memory reads at base+0 .. base+WORDS-1, one per cycle, with `mem_rdata` valid in the cycle `mem_addr` is presented. The new base equals the missed address. The grant appears WORDS+1 cycles after the request when no copy-back is needed.
- R4: A line base need not be a multiple of WORDS. A line loaded at a non-aligned address covers exactly the WORDS following addresses.
- R5: A write that hits stores `wdata` into the matching word at the clock edge, so a later read returns it. The write also marks that line dirty.
- R6: When the line to be reloaded is dirty, its WORDS words are first written to memory at its old base (`mem_we` high). The reload follows, and the grant arrives 2*WORDS+1 cycles after the request.
- R7: When several valid lines cover an address, the lowest-numbered line serves it. Only that line is updated by a write.
- R8: Misses are served one at a time. The arbiter searches requesters in rotating order, starting just after the requester served last (port index wraps to 0 after the last port).
- R9: Port NREQ is the weight port with its own line. Any port may hit in any line, including the weight line.
- R10: Memory traffic starts only in the cycle after some request missed. The port stays idle while all requests hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NREQ+1 | Request per port; bit NREQ is the weight port |
| we | input | NREQ+1 | Write (1) or read (0) per port |
| addr | input | (NREQ+1)*AW | Word address per port, port i at bits i*AW upward |
| wdata | input | (NREQ+1)*DW | Write data per port |
| gnt | output | NREQ+1 | Request served this cycle |
| rdata | output | (NREQ+1)*DW | Read data per port, valid with gnt |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write (copy-back) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data for the current mem_addr |

## Verification
The bench builds the block with three requester ports plus the weight port, four-word lines and a 12-bit address. With these settings a reload takes a few cycles, so exact grant latency can be counted. Overlapping lines from two ports can be set up with a handful of accesses, and the rotating arbiter wraps past the weight port within a short sequence. Copy-back is observed in a memory model held by the bench. That model shows a write reaching only the lowest overlapping line.

// File: rtl/nmc_share_buf.sv
module nmc_share_buf #(
  parameter int NREQ  = 16,
  parameter int WORDS = 16,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NREQ:0]              req,
  input  logic [NREQ:0]              we,
  input  logic [(NREQ+1)*AW-1:0]     addr,
  input  logic [(NREQ+1)*DW-1:0]     wdata,
  output logic [NREQ:0]              gnt,
  output logic [(NREQ+1)*DW-1:0]     rdata,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [AW-1:0]              mem_addr,
  output logic [DW-1:0]              mem_wdata,
  input  logic [DW-1:0]              mem_rdata
);
  localparam int NB = NREQ + 1;
  localparam int IW = $clog2(NB);
  localparam int OW = $clog2(WORDS);
  localparam logic [OW-1:0] LAST = OW'(WORDS - 1);

  typedef enum logic [1:0] {IDLE, WB, FILL} st_t;

  logic [DW-1:0] data_q [NB][WORDS];
  logic [AW-1:0] base_q [NB];
  logic [NB-1:0] vld_q, dirty_q;
  st_t           st_q;
  logic [OW-1:0] cnt_q;
  logic [IW-1:0] cur_q, ptr_q;
  logic [AW-1:0] maddr_q;

  logic [NB-1:0] hit, miss, wmask;
  logic [IW-1:0] hsel [NB];
  logic [OW-1:0] hoff [NB];
  logic [IW-1:0] pick;
  logic          found;

  always_comb begin
    logic [AW-1:0] d;
    for (int i = 0; i < NB; i++) begin
      hit[i]  = 1'b0;
      hsel[i] = '0;
      hoff[i] = '0;
      for (int j = NB - 1; j >= 0; j--) begin
        d = addr[i*AW +: AW] - base_q[j];
        if (vld_q[j] && d < AW'(WORDS)) begin
          hit[i]  = 1'b1;
          hsel[i] = IW'(j);
          hoff[i] = d[OW-1:0];
        end
      end
    end
  end

  assign gnt  = req & hit;
  assign miss = req & ~hit;

  for (genvar i = 0; i < NB; i++) begin : g_rd
    assign rdata[i*DW +: DW] = data_q[hsel[i]][hoff[i]];
  end

  always_comb begin
    wmask = '0;
    for (int i = 0; i < NB; i++)
      if (gnt[i] && we[i]) wmask[hsel[i]] = 1'b1;
  end

  always_comb begin
    int t;
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NB; k++) begin
      t = int'(ptr_q) + k;
      if (t >= NB) t = t - NB;
      if (!found && miss[t]) begin
        found = 1'b1;
        pick  = t[IW-1:0];
      end
    end
  end

  assign mem_req   = (st_q != IDLE);
  assign mem_we    = (st_q == WB);
  assign mem_addr  = ((st_q == WB) ? base_q[cur_q] : maddr_q) + AW'(cnt_q);
  assign mem_wdata = data_q[cur_q][cnt_q];

  always_ff @(posedge clk) begin
    for (int i = NB - 1; i >= 0; i--)
      if (gnt[i] && we[i]) data_q[hsel[i]][hoff[i]] <= wdata[i*DW +: DW];
    if (st_q == FILL) begin
      data_q[cur_q][cnt_q] <= mem_rdata;
      if (cnt_q == LAST) base_q[cur_q] <= maddr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= IDLE;
      cnt_q   <= '0;
      cur_q   <= '0;
      ptr_q   <= '0;
      maddr_q <= '0;
      vld_q   <= '0;
      dirty_q <= '0;
    end else begin
      dirty_q <= dirty_q | wmask;
      case (st_q)
        IDLE: if (found) begin
          cur_q        <= pick;
          maddr_q      <= addr[pick*AW +: AW];
          vld_q[pick]  <= 1'b0;
          cnt_q        <= '0;
          st_q         <= (dirty_q[pick] || wmask[pick]) ? WB : FILL;
        end
        WB: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            st_q           <= FILL;
            dirty_q[cur_q] <= 1'b0;
          end
        end
        FILL: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            st_q         <= IDLE;
            vld_q[cur_q] <= 1'b1;
            ptr_q        <= (cur_q == IW'(NB - 1)) ? '0 : cur_q + 1'b1;
          end
        end
        default: st_q <= IDLE;
      endcase
    end
  end

  assert_fill_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FILL && cnt_q == LAST) |=>
      (vld_q[$past(cur_q)] && base_q[$past(cur_q)] == $past(maddr_q)));

  assert_wb_to_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WB && cnt_q == LAST) |=> (st_q == FILL && !dirty_q[cur_q]));

  assert_single_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != IDLE && !(st_q == FILL && cnt_q == LAST)) |=>
      ($stable(cur_q) && st_q != IDLE));

  assert_mem_after_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(|miss));

  for (genvar i = 0; i < NB; i++) begin : g_chk
    assert_write_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt[i] && we[i]) |=> dirty_q[$past(hsel[i])]);
  end
endmodule

// File: tb/nmc_share_buf_bench.sv
module nmc_share_buf_bench;
  localparam int NREQ = 3, NB = NREQ + 1, WORDS = 4, AW = 12, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NB-1:0] req = '0, we = '0, gnt;
  logic [NB*AW-1:0] addr = '0;
  logic [NB*DW-1:0] wdata = '0, rdata;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  nmc_share_buf #(.NREQ(NREQ), .WORDS(WORDS), .AW(AW), .DW(DW)) u_nmc_share_buf (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .gnt(gnt), .rdata(rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  function automatic logic [31:0] fmem(int a);
    return 32'h1000_0000 + 32'(a * 7);
  endfunction

  logic [31:0] mem [1 << AW];
  int wcnt = 0, total = 0, bad = 0;
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk)
    if (mem_req && mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wcnt++;
    end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // port, we, miss, addr, wdata, expected read (0 = memory pattern)
  localparam logic [81:0] TBL [8] = '{
    {4'd1, 1'b0, 1'b1, 12'h022, 32'h0, 32'h0},          // R3 R4 load non-aligned
    {4'd0, 1'b0, 1'b1, 12'h020, 32'h0, 32'h0},          // R3
    {4'd2, 1'b0, 1'b0, 12'h025, 32'h0, 32'h0},          // R4 last word of line at 0x22
    {4'd2, 1'b1, 1'b0, 12'h022, 32'hAAAA5555, 32'h0},   // R5 R7 overlap write
    {4'd1, 1'b0, 1'b0, 12'h022, 32'h0, 32'hAAAA5555},   // R5 read back
    {4'd1, 1'b0, 1'b0, 12'h024, 32'h0, 32'h0},          // R2
    {4'd3, 1'b0, 1'b1, 12'h100, 32'h0, 32'h0},          // R9 weight line
    {4'd0, 1'b0, 1'b0, 12'h103, 32'h0, 32'h0}           // R9 shared hit
  };

  task automatic access(int p, logic w, int a, logic [31:0] wd,
                        output logic first_gnt, output int lat, output logic [31:0] rd);
    @(negedge clk);
    req[p] = 1'b1; we[p] = w;
    addr[p*AW +: AW] = AW'(a); wdata[p*DW +: DW] = wd;
    #1;
    first_gnt = gnt[p];
    lat = 0;
    while (!gnt[p]) begin
      @(negedge clk); #1;
      lat++;
    end
    rd = rdata[p*DW +: DW];
    @(negedge clk);
    req[p] = 1'b0; we[p] = 1'b0;
  endtask

  task automatic pair(int pa, int aa, int pb, int ab, output int first, output int second);
    @(negedge clk);
    req[pa] = 1'b1; addr[pa*AW +: AW] = AW'(aa);
    req[pb] = 1'b1; addr[pb*AW +: AW] = AW'(ab);
    #1;
    first = -1; second = -1;
    while (second < 0) begin
      if (gnt[pa] && gnt[pb]) begin first = 9; second = 9; end
      else if (gnt[pa] && req[pa]) begin
        if (first < 0) first = pa; else second = pa;
        @(negedge clk); req[pa] = 1'b0; #1;
        continue;
      end else if (gnt[pb] && req[pb]) begin
        if (first < 0) first = pb; else second = pb;
        @(negedge clk); req[pb] = 1'b0; #1;
        continue;
      end
      @(negedge clk); #1;
    end
    @(negedge clk);
    req[pa] = 1'b0; req[pb] = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    bad++;
    $display("FAIL watchdog R1 act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic fg;
    int lat, f1, s1;
    logic [31:0] rd;
    for (int a = 0; a < (1 << AW); a++) mem[a] = fmem(a);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 gnt idle", 32'(gnt), 32'h0);
    check("R1 mem_req idle", 32'(mem_req), 32'h0);

    for (int k = 0; k < 8; k++) begin
      logic [81:0] e;
      logic [31:0] ex;
      e = TBL[k];
      access(int'(e[81:78]), e[77], int'(e[75:64]), e[63:32], fg, lat, rd);
      check($sformatf("R2/R3 grant-at-request entry %0d", k), 32'(fg), 32'(!e[76]));
      if (e[76]) check($sformatf("R3 latency entry %0d", k), 32'(lat), 32'(WORDS + 1));
      if (!e[77]) begin
        ex = (e[31:0] == 0) ? fmem(int'(e[75:64])) : e[31:0];
        check($sformatf("R2 rdata entry %0d", k), rd, ex);
      end
    end

    check("R10 no traffic while hitting", 32'(wcnt), 32'h0);
    #1 check("R10 mem_req idle", 32'(mem_req), 32'h0);

    access(0, 1'b0, 12'h040, 32'h0, fg, lat, rd);
    check("R6 dirty reload latency", 32'(lat), 32'(2 * WORDS + 1));
    check("R6 copy-back count", 32'(wcnt), 32'(WORDS));
    check("R6 written word copied back", mem[12'h022], 32'hAAAA5555);
    check("R6 clean word copied back", mem[12'h021], fmem(12'h021));
    check("R3 new line data", rd, fmem(12'h040));

    access(1, 1'b0, 12'h050, 32'h0, fg, lat, rd);
    check("R7 upper overlapping line stayed clean", 32'(wcnt), 32'(WORDS));
    check("R7 clean reload latency", 32'(lat), 32'(WORDS + 1));

    pair(0, 12'h060, 2, 12'h070, f1, s1);
    check("R8 rotation first", 32'(f1), 32'd2);
    check("R8 rotation second", 32'(s1), 32'd0);
    pair(0, 12'h080, 1, 12'h090, f1, s1);
    check("R8 rotation after port 0", 32'(f1), 32'd1);
    check("R8 rotation then port 0", 32'(s1), 32'd0);

    access(2, 1'b1, 12'h073, 32'h5A5A0001, fg, lat, rd);
    check("R5 write hit immediate", 32'(fg), 32'h1);
    access(3, 1'b0, 12'h073, 32'h0, fg, lat, rd);
    check("R5 written word seen by other port", rd, 32'h5A5A0001);
    check("R5 hit no wait", 32'(fg), 32'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule